// File: doc/BRIEF.md
# Whole-Page Single-Error-Correcting Flash Parity Engine

This block sits beside a flash data bus and observes every data word that crosses it during a page transfer. It never drives the bus and never alters data. Over a whole page (data plus spare area) it accumulates one Hamming-style code. The code has two 16-bit halves. The first is the XOR of the bit index of every set data bit. The second is the XOR of the complement of those indices. The bit index of a data bit is `{word_address[11:0], bit_position[3:0]}`, and the word address counts strobed words from zero modulo 4096.

When a page is written, software reads the two halves once the page words have been strobed and stores them as four check bytes. When a page is read back, the stored check bytes must follow the page words at once. The engine folds them into its accumulators, which leaves a 32-bit syndrome. It then classifies that syndrome. A zero syndrome means a clean page. Halves that are exact complements mean one flipped data bit, and its location is reported. A syndrome with exactly one bit set means a flip inside the stored code. Anything else is an uncorrectable multiple error. A blank erased page falls into the multiple-error class with every location bit set, which lets software recognise it.

A synchronous clear command restarts the calculation at any point, for example after the address cycles of a transfer.

Top module: `page_ecc`

## Requirements
- R1: After reset or after a cycle with `clr` high, `parity_out` and `nparity_out` read 0 and `done`, `err_rec`, `err_mul` and `err_code` read 0.
- R2: Once all page words have been strobed, and before any check word arrives, `parity_out` equals the XOR over all set data bits of `{addr[11:0], bit[3:0]}`, and `nparity_out` equals the XOR of the complements of those indices.
- R3: `din` has no effect on any output in cycles where `strobe` is low.
- R4: `page_sel` values 0, 1, 2 and 3 select 528, 1056, 2112 and 4224 bytes. The page holds that many words in 8-bit mode and half that many in 16-bit mode (`wide`=1). `done` rises in the cycle after the last check word is strobed and stays low before that.
- R5: The check words follow the page words. In 8-bit mode there are four bytes: parity low byte, parity high byte, inverse-parity low byte, inverse-parity high byte. In 16-bit mode there are two words: parity, then inverse parity. When the stored code matches the data, all flags read 0 after `done` and `parity_out` reads 0.
- R6: When exactly one data bit differs from the written page, `err_rec`=1, `err_mul`=0 and `err_code`=0, and `parity_out` gives the word address in bits [15:4] and the bit offset in bits [3:0].
- R7: When exactly one bit of the 32 stored check bits is flipped, `err_rec`=1, `err_code`=1, `err_mul`=0 and `parity_out`=0.
- R8: When two data bits differ, `err_rec`=1, `err_mul`=1, `err_code`=0 and `parity_out`=16'hFFFF.
- R9: An erased page (all data bits one, all check bytes 8'hFF) reports as in R8, with bit offset 4'hF and word address 12'hFFF.
- R10: After `done`, further strobes do not change `parity_out`, `nparity_out` or any flag until `clr`.
- R11: A `clr` in the middle of a transfer discards the words already seen. A complete page that follows is then checked correctly.
- R12: In 8-bit mode `din[15:8]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous restart command |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| page_sel | input | 2 | Page length select |
| strobe | input | 1 | Data word valid on the bus |
| din | input | 16 | Bus data word |
| parity_out | output | 16 | Parity half; after `done`, the error location |
| nparity_out | output | 16 | Inverse-parity half; after `done`, its syndrome |
| done | output | 1 | Page and check words consumed |
| err_rec | output | 1 | Nonzero syndrome |
| err_mul | output | 1 | Uncorrectable error |
| err_code | output | 1 | Single flip inside the stored code |

## Verification
The bench injects single flips at random words and bits, including bit 7 in 8-bit mode and bit 15 in 16-bit mode. A design that mis-indexed bits or words would report a wrong location there. It also flips each kind of stored check bit: a classifier that tested only the complement relation would call these data errors or multiple errors. Erased pages and double flips must both land in the multiple class with an all-ones location; a design that leaked the raw syndrome would show it in `parity_out`. Idle cycles with junk on the bus, junk on the upper byte in 8-bit mode, extra strobes after `done`, and a clear in mid-transfer each catch an engine that samples when it should not, or that keeps stale state.

// File: rtl/page_ecc.sv
module page_ecc #(
  parameter int DW = 16,
  parameter int AW = 12,
  parameter int BW = 4,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wide,
  input  logic [1:0]    page_sel,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic [15:0]   parity_out,
  output logic [15:0]   nparity_out,
  output logic          done,
  output logic          err_rec,
  output logic          err_mul,
  output logic          err_code
);
  localparam int IW = AW + BW;

  logic [CW-1:0] cnt, pw, total, k;
  logic [IW-1:0] p_acc, np_acc, p_d, np_d;
  logic          in_page, nz, single, onebit, mul;

  assign pw      = wide ? (CW'(264) << page_sel) : (CW'(528) << page_sel);
  assign total   = pw + (wide ? CW'(2) : CW'(4));
  assign in_page = cnt < pw;
  assign k       = cnt - pw;

  always_comb begin
    p_d  = '0;
    np_d = '0;
    for (int j = 0; j < DW; j++) begin
      if ((wide || j < 8) && din[j]) begin
        p_d  = p_d  ^ {cnt[AW-1:0], BW'(j)};
        np_d = np_d ^ ~{cnt[AW-1:0], BW'(j)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      p_acc  <= '0;
      np_acc <= '0;
      done   <= 1'b0;
    end else if (clr) begin
      cnt    <= '0;
      p_acc  <= '0;
      np_acc <= '0;
      done   <= 1'b0;
    end else if (strobe && !done) begin
      cnt <= cnt + 1'b1;
      if (in_page) begin
        p_acc  <= p_acc ^ p_d;
        np_acc <= np_acc ^ np_d;
      end else if (wide) begin
        if (k[0]) np_acc <= np_acc ^ din[15:0];
        else      p_acc  <= p_acc ^ din[15:0];
      end else begin
        case (k[1:0])
          2'd0: p_acc[7:0]   <= p_acc[7:0]   ^ din[7:0];
          2'd1: p_acc[15:8]  <= p_acc[15:8]  ^ din[7:0];
          2'd2: np_acc[7:0]  <= np_acc[7:0]  ^ din[7:0];
          default: np_acc[15:8] <= np_acc[15:8] ^ din[7:0];
        endcase
      end
      if (cnt == total - 1'b1) done <= 1'b1;
    end
  end

  assign nz     = |{np_acc, p_acc};
  assign single = (p_acc == ~np_acc);
  assign onebit = $onehot({np_acc, p_acc});
  assign mul    = nz && !single && !onebit;

  assign err_rec     = done && nz;
  assign err_mul     = done && mul;
  assign err_code    = done && onebit;
  assign parity_out  = !done ? p_acc : mul ? 16'hFFFF : single ? p_acc : 16'h0000;
  assign nparity_out = np_acc;

  // R7 R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_mul && err_code));

  // R6
  flag_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mul || err_code) |-> err_rec);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (done && $stable(parity_out) && $stable(nparity_out)));

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!done && parity_out == 16'h0 && nparity_out == 16'h0));

  // R4
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(err_rec || err_mul || err_code));
endmodule

// File: tb/page_ecc_bench.sv
module page_ecc_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, clr = 0, wide = 0, strobe = 0;
  logic [1:0] page_sel = 0;
  logic [15:0] din = 0;
  logic [15:0] parity_out, nparity_out;
  logic done, err_rec, err_mul, err_code;
  int checks = 0, errors = 0;
  bit finished = 0;
  bit gaps = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_ecc u_page_ecc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wide(wide), .page_sel(page_sel),
    .strobe(strobe), .din(din), .parity_out(parity_out),
    .nparity_out(nparity_out), .done(done), .err_rec(err_rec),
    .err_mul(err_mul), .err_code(err_code));

  function automatic logic [31:0] word_code(input logic [15:0] w, input int addr, input bit w16);
    logic [15:0] p = 0, np = 0, idx;
    for (int j = 0; j < (w16 ? 16 : 8); j++)
      if (w[j]) begin
        idx = {addr[11:0], j[3:0]};
        p  ^= idx;
        np ^= ~idx;
      end
    return {np, p};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    if (gaps && ($urandom % 4 == 0)) begin
      @(negedge clk); strobe = 0; din = 16'($urandom);
    end
    @(negedge clk); strobe = 1; din = w;
  endtask

  task automatic idle();
    @(negedge clk); strobe = 0; din = 16'($urandom);
  endtask

  task automatic do_clr();
    @(negedge clk); strobe = 0; clr = 1;
    @(negedge clk); clr = 0;
    chk("R1 clr parity", {nparity_out, parity_out}, 32'h0);
    chk("R1 clr flags", {28'h0, done, err_rec, err_mul, err_code}, 32'h0);
  endtask

  // nerr: data flips (0..2); cbit: flipped check bit or -1
  task automatic run_page(input bit w16, input int sel, input int nerr,
                          input int cbit, input bit erased, input int force_w);
    int pw, e0, e1, b0, b1;
    logic [31:0] ref_c, stored, exp_flags;
    logic [15:0] w, sent, exp_loc;
    logic [31:0] hold;
    wide = w16; page_sel = 2'(sel);
    pw = (w16 ? 264 : 528) << sel;
    e0 = (force_w >= 0) ? force_w : int'($urandom % pw);
    e1 = (e0 + 1 + int'($urandom % (pw - 1))) % pw;
    b0 = (force_w >= 0) ? (w16 ? 15 : 7) : int'($urandom % (w16 ? 16 : 8));
    b1 = int'($urandom % (w16 ? 16 : 8));
    ref_c = 0;
    for (int i = 0; i < pw; i++) begin
      w = erased ? 16'hFFFF : 16'($urandom);
      ref_c ^= word_code(w, i, w16);
      sent = w;
      if (nerr >= 1 && i == e0) sent[b0] = ~sent[b0];
      if (nerr >= 2 && i == e1) sent[b1] = ~sent[b1];
      put(sent);
    end
    idle();
    if (nerr == 0) chk("R2 write code", {nparity_out, parity_out}, ref_c);
    chk("R4 not done after page", {31'h0, done}, 32'h0);
    stored = erased ? 32'hFFFF_FFFF : ref_c;
    if (cbit >= 0) stored[cbit] = ~stored[cbit];
    if (w16) begin
      put(stored[15:0]);
      idle();
      chk("R4 not done before last", {31'h0, done}, 32'h0);
      put(stored[31:16]);
    end else begin
      put({8'($urandom), stored[7:0]});
      put({8'($urandom), stored[15:8]});
      put({8'($urandom), stored[23:16]});
      idle();
      chk("R4 not done before last", {31'h0, done}, 32'h0);
      put({8'($urandom), stored[31:24]});
    end
    idle();
    chk("R4 done", {31'h0, done}, 32'h1);
    exp_loc = 16'h0;
    if (erased || nerr == 2) begin
      exp_flags = 32'b110; exp_loc = 16'hFFFF;
    end else if (nerr == 1) begin
      exp_flags = 32'b100;
      exp_loc = w16 ? {e0[11:0], b0[3:0]} : {e0[11:0], 1'b0, b0[2:0]};
    end else if (cbit >= 0) begin
      exp_flags = 32'b101;
    end else begin
      exp_flags = 32'b000;
    end
    if (erased)         chk("R9 erased flags", {29'h0, err_rec, err_mul, err_code}, exp_flags);
    else if (nerr == 2) chk("R8 multi flags", {29'h0, err_rec, err_mul, err_code}, exp_flags);
    else if (nerr == 1) chk("R6 single flags", {29'h0, err_rec, err_mul, err_code}, exp_flags);
    else if (cbit >= 0) chk("R7 code flags", {29'h0, err_rec, err_mul, err_code}, exp_flags);
    else                chk("R5 clean flags", {29'h0, err_rec, err_mul, err_code}, exp_flags);
    if (erased)         chk("R9 erased loc", {16'h0, parity_out}, {16'h0, exp_loc});
    else if (nerr == 2) chk("R8 multi loc", {16'h0, parity_out}, {16'h0, exp_loc});
    else if (nerr == 1) chk("R6 location", {16'h0, parity_out}, {16'h0, exp_loc});
    else if (cbit >= 0) chk("R7 code loc", {16'h0, parity_out}, {16'h0, exp_loc});
    else                chk("R5 clean loc", {16'h0, parity_out}, {16'h0, exp_loc});
    hold = {nparity_out, parity_out};
    for (int i = 0; i < 3; i++) put(16'($urandom));
    idle();
    chk("R10 hold", {nparity_out, parity_out}, hold);
    chk("R10 flags", {29'h0, err_rec, err_mul, err_code}, exp_flags);
    do_clr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset", {nparity_out, parity_out}, 32'h0);
    chk("R1 reset flags", {28'h0, done, err_rec, err_mul, err_code}, 32'h0);
    rst_n = 1;
    // R2 R4 R5 R12: clean pages, every length and width
    for (int s = 0; s < 4; s++) begin
      run_page(0, s, 0, -1, 0, -1);
      run_page(1, s, 0, -1, 0, -1);
    end
    // R3: idle junk between words
    gaps = 1;
    run_page(0, 0, 1, -1, 0, -1);
    run_page(1, 1, 0, -1, 0, -1);
    gaps = 0;
    // R6: single data flips, random and last word top bit
    for (int i = 0; i < 4; i++) run_page(i[0], i % 2, 1, -1, 0, -1);
    run_page(0, 0, 1, -1, 0, 527);
    run_page(1, 0, 1, -1, 0, 263);
    run_page(0, 3, 1, -1, 0, 4223);
    // R7: check code flips
    run_page(0, 0, 0, 0, 0, -1);
    run_page(0, 0, 0, 31, 0, -1);
    run_page(1, 0, 0, 9, 0, -1);
    run_page(1, 1, 0, 20, 0, -1);
    // R8: double flips
    run_page(0, 0, 2, -1, 0, -1);
    run_page(1, 0, 2, -1, 0, -1);
    // R9: erased pages
    run_page(0, 0, 0, -1, 1, -1);
    run_page(1, 2, 0, -1, 1, -1);
    // R11: clear after junk words then a full page
    wide = 0; page_sel = 0;
    for (int i = 0; i < 5; i++) put(16'($urandom));
    do_clr();
    run_page(0, 0, 1, -1, 0, -1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule